// File: doc/BRIEF.md
# Memory-Window Serial Flash Bridge

The bridge sits between a simple host request port and a 4-wire serial flash (select, clock, data out, data in). The host sees the flash as a block of memory: any request whose address lands inside a programmable base window is claimed. The bridge turns it into single-byte flash transactions, one select frame per byte. Requests outside the window are left alone.

Serial transfers take hundreds of system cycles, so the host port never stalls. A read that starts a sequence is answered with a retry. Every claimed request that arrives while a sequence runs is also answered with a retry. Once the bytes have been gathered, the host repeats the same read and receives the assembled word.

Writes are byte-wide only and are gated by a 2-bit write-enable code. An accepted byte write runs three steps: a write-enable command, a program command, and a loop of status reads. The loop continues until the flash reports that it has finished. A busy output stays high for the whole of that program operation so software can poll it.

Top module: `msfb_bridge`

## Requirements
- R1: A request is claimed only when `winBase <= hostAddr < winBase + 2**WIN_AW`. An unclaimed request, or a cycle without `hostValid`, produces neither `respAck` nor `respRetry` in the next cycle and starts no flash traffic.
- R2: A read of `hostSize` 0, 1 or 2 (1, 2 or 4 bytes; code 3 acts as 2) is served as that many separate select frames.
  - Each frame carries opcode 0x03, a 24-bit address of (offset + k) and one data byte.
  - Byte k of the result is placed in `respRdata[8k+7:8k]`, and unused upper bytes read as zero.
- R3: Every response comes one cycle after the request and is either an ack or a retry, never both.
  - A claimed read that starts a sequence gets a retry.
  - A claimed request of any kind that arrives while a sequence runs gets a retry.
  - Repeating the same address and size after the sequence ends gets `respAck` with the data.
- R4: A claimed byte write (`hostSize` 0) with `wrEnCode` other than 01 is acked.
  - It then produces three kinds of frame in this order: a frame with opcode 0x06; a frame with opcode 0x02, a 24-bit address and the data byte `hostWdata`; and frames with opcode 0x05 that read one status byte.
- R5: A claimed write with `hostSize` other than 0 is acked and dropped: no flash traffic and no busy.
- R6: With `wrEnCode` = 01, a claimed write is acked and dropped: no flash traffic, no busy, and the flash content is unchanged.
- R7: `busy` rises in the cycle of the ack of an accepted byte write. It falls only after a status read returns bit 0 clear. Status frames repeat while bit 0 reads 1.
- R8: The serial clock idles low whenever select is high.
  - Each serial clock half-period lasts `CLK_DIV` system cycles.
  - Data out changes only while the serial clock is low, and is sent MSB first.
  - Data in is sampled on the rising edge.
- R9: Between frames, select stays high for at least two serial clock periods (`4*CLK_DIV` system cycles).
- R10: After reset, select is high, the serial clock is low, `busy` is low and there is no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| winBase | input | ADDR_W | Base address of the flash window |
| wrEnCode | input | 2 | Write-enable code; 01 blocks writes |
| hostValid | input | 1 | Host request present this cycle |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | ADDR_W | Host byte address |
| hostSize | input | 2 | Log2 of access width in bytes |
| hostWdata | input | 8 | Write data byte |
| respAck | output | 1 | Request completed |
| respRetry | output | 1 | Request must be repeated |
| respRdata | output | 32 | Assembled read data, valid with ack of a read |
| busy | output | 1 | Flash program operation in progress |
| flashCsN | output | 1 | Flash select, active low |
| flashSck | output | 1 | Serial clock |
| flashMosi | output | 1 | Serial data to flash |
| flashMiso | input | 1 | Serial data from flash |

## Verification
The hardest situation to reach is a write that finishes only after several status reads, with host requests arriving while that loop runs. The bench flash model keeps its busy flag set for three status reads after each program command. The bench issues a read during that window and expects a retry. It then checks the full opcode trail of six frames and the read-back value. Retry during a multi-byte read is forced by firing a write between the read that starts the sequence and its repeat.

// File: rtl/msfb_pkg.sv
package msfb_pkg;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_STAT = 8'h05;
  localparam logic [1:0] WR_BLOCKED = 2'b01;

  typedef enum logic [1:0] {CMD_RD, CMD_WREN, CMD_PROG, CMD_POLL} cmdKind_t;

  typedef struct packed {
    logic       csAssert;
    logic       xferStart;
    logic [7:0] txByte;
    logic       capClear;
    logic       capLoad;
    logic [1:0] capLane;
  } dpCtrl_t;
endpackage

// File: rtl/msfb_datapath.sv
module msfb_datapath
  import msfb_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpCtrl_t     ctrl,
  input  logic        flashMiso,
  output logic        xferDone,
  output logic [7:0]  rxByte,
  output logic [31:0] asmWord,
  output logic        flashCsN,
  output logic        flashSck,
  output logic        flashMosi
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] HALF_LAST = DIV_W'(CLK_DIV - 1);

  logic             active;
  logic [DIV_W-1:0] halfCnt;
  logic [2:0]       bitCnt;
  logic [7:0]       txSh;
  logic [7:0]       rxSh;

  assign rxByte = rxSh;

  // Mode-0 byte shifter: drive on falling edge, sample on rising edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      halfCnt   <= '0;
      bitCnt    <= '0;
      txSh      <= '0;
      rxSh      <= '0;
      flashSck  <= 1'b0;
      flashMosi <= 1'b0;
      flashCsN  <= 1'b1;
      xferDone  <= 1'b0;
    end else begin
      flashCsN <= !ctrl.csAssert;
      xferDone <= 1'b0;
      if (ctrl.xferStart) begin
        active    <= 1'b1;
        txSh      <= ctrl.txByte;
        flashMosi <= ctrl.txByte[7];
        halfCnt   <= '0;
        bitCnt    <= '0;
        flashSck  <= 1'b0;
      end else if (active) begin
        if (halfCnt == HALF_LAST) begin
          halfCnt <= '0;
          if (!flashSck) begin
            flashSck <= 1'b1;
            rxSh     <= {rxSh[6:0], flashMiso};
          end else begin
            flashSck <= 1'b0;
            if (bitCnt == 3'd7) begin
              active   <= 1'b0;
              xferDone <= 1'b1;
            end else begin
              bitCnt    <= bitCnt + 3'd1;
              txSh      <= {txSh[6:0], 1'b0};
              flashMosi <= txSh[6];
            end
          end
        end else begin
          halfCnt <= halfCnt + DIV_W'(1);
        end
      end
    end
  end

  // Word assembly from byte lanes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      asmWord <= '0;
    end else if (ctrl.capClear) begin
      asmWord <= '0;
    end else if (ctrl.capLoad) begin
      asmWord[8*ctrl.capLane +: 8] <= rxSh;
    end
  end
endmodule

// File: rtl/msfb_control.sv
module msfb_control
  import msfb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int WIN_AW  = 24,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] winBase,
  input  logic [1:0]        wrEnCode,
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        hostSize,
  input  logic [7:0]        hostWdata,
  input  logic              xferDone,
  input  logic [7:0]        rxByte,
  input  logic [31:0]       asmWord,
  output logic              respAck,
  output logic              respRetry,
  output logic [31:0]       respRdata,
  output logic              busy,
  output dpCtrl_t           ctrl
);
  localparam int GAP_CYC = 4 * CLK_DIV;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_WAIT, S_GAP} state_t;

  state_t            state;
  cmdKind_t          cmd;
  logic [2:0]        byteIdx;
  logic [1:0]        rdLane, rdLast;
  logic [23:0]       baseOff;
  logic [7:0]        progData;
  logic [GAP_W-1:0]  gapCnt;
  logic              pollBusy;
  logic              readyValid;
  logic [ADDR_W-1:0] readyAddr;
  logic [1:0]        readySize;

  logic [ADDR_W-1:0] offset;
  logic              inWin, claimed, idle, readHit, startRead, startProg;
  logic [1:0]        sizeEff, nLast;
  logic [23:0]       flashAddr;
  logic [2:0]        lastIdx;
  logic [7:0]        txByte;

  // Host decode
  always_comb begin
    offset    = hostAddr - winBase;
    inWin     = (hostAddr >= winBase) && ((offset >> WIN_AW) == '0);
    claimed   = hostValid && inWin;
    idle      = (state == S_IDLE);
    sizeEff   = (hostSize == 2'd3) ? 2'd2 : hostSize;
    case (sizeEff)
      2'd0:    nLast = 2'd0;
      2'd1:    nLast = 2'd1;
      default: nLast = 2'd3;
    endcase
    readHit   = readyValid && (readyAddr == hostAddr) && (readySize == sizeEff);
    startRead = claimed && idle && !hostWrite && !readHit;
    startProg = claimed && idle && hostWrite && (hostSize == 2'd0) && (wrEnCode != WR_BLOCKED);
  end

  // Command byte selection
  always_comb begin
    flashAddr = baseOff + 24'(rdLane);
    case (cmd)
      CMD_WREN: lastIdx = 3'd0;
      CMD_POLL: lastIdx = 3'd1;
      default:  lastIdx = 3'd4;
    endcase
    txByte = 8'h00;
    if (byteIdx == 3'd0) begin
      case (cmd)
        CMD_RD:   txByte = OP_READ;
        CMD_WREN: txByte = OP_WREN;
        CMD_PROG: txByte = OP_PROG;
        default:  txByte = OP_STAT;
      endcase
    end else if (cmd == CMD_RD || cmd == CMD_PROG) begin
      case (byteIdx)
        3'd1:    txByte = flashAddr[23:16];
        3'd2:    txByte = flashAddr[15:8];
        3'd3:    txByte = flashAddr[7:0];
        default: txByte = (cmd == CMD_PROG) ? progData : 8'h00;
      endcase
    end
  end

  always_comb begin
    ctrl.csAssert  = (state == S_START) || (state == S_WAIT);
    ctrl.xferStart = (state == S_START);
    ctrl.txByte    = txByte;
    ctrl.capClear  = startRead;
    ctrl.capLoad   = (state == S_WAIT) && xferDone && (cmd == CMD_RD) && (byteIdx == 3'd4);
    ctrl.capLane   = rdLane;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      cmd        <= CMD_RD;
      byteIdx    <= '0;
      rdLane     <= '0;
      rdLast     <= '0;
      baseOff    <= '0;
      progData   <= '0;
      gapCnt     <= '0;
      pollBusy   <= 1'b0;
      readyValid <= 1'b0;
      readyAddr  <= '0;
      readySize  <= '0;
      respAck    <= 1'b0;
      respRetry  <= 1'b0;
      respRdata  <= '0;
      busy       <= 1'b0;
    end else begin
      respAck   <= 1'b0;
      respRetry <= 1'b0;
      if (claimed) begin
        if (!idle) begin
          respRetry <= 1'b1;
        end else if (hostWrite) begin
          respAck    <= 1'b1;
          readyValid <= 1'b0;
          if (startProg) begin
            cmd      <= CMD_WREN;
            byteIdx  <= '0;
            rdLane   <= '0;
            baseOff  <= offset[23:0];
            progData <= hostWdata;
            busy     <= 1'b1;
            state    <= S_START;
          end
        end else if (readHit) begin
          respAck    <= 1'b1;
          respRdata  <= asmWord;
          readyValid <= 1'b0;
        end else begin
          respRetry  <= 1'b1;
          readyValid <= 1'b0;
          readyAddr  <= hostAddr;
          readySize  <= sizeEff;
          cmd        <= CMD_RD;
          byteIdx    <= '0;
          rdLane     <= '0;
          rdLast     <= nLast;
          baseOff    <= offset[23:0];
          state      <= S_START;
        end
      end

      case (state)
        S_START: state <= S_WAIT;
        S_WAIT: if (xferDone) begin
          if (cmd == CMD_POLL && byteIdx == 3'd1) pollBusy <= rxByte[0];
          if (byteIdx == lastIdx) begin
            gapCnt <= '0;
            state  <= S_GAP;
          end else begin
            byteIdx <= byteIdx + 3'd1;
            state   <= S_START;
          end
        end
        S_GAP: begin
          if (gapCnt == GAP_LAST) begin
            byteIdx <= '0;
            state   <= S_START;
            case (cmd)
              CMD_RD: begin
                if (rdLane == rdLast) begin
                  readyValid <= 1'b1;
                  state      <= S_IDLE;
                end else begin
                  rdLane <= rdLane + 2'd1;
                end
              end
              CMD_WREN: cmd <= CMD_PROG;
              CMD_PROG: cmd <= CMD_POLL;
              default: begin
                if (!pollBusy) begin
                  busy  <= 1'b0;
                  state <= S_IDLE;
                end
              end
            endcase
          end else begin
            gapCnt <= gapCnt + GAP_W'(1);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/msfb_bridge.sv
module msfb_bridge
  import msfb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int WIN_AW  = 24,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] winBase,
  input  logic [1:0]        wrEnCode,
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        hostSize,
  input  logic [7:0]        hostWdata,
  output logic              respAck,
  output logic              respRetry,
  output logic [31:0]       respRdata,
  output logic              busy,
  output logic              flashCsN,
  output logic              flashSck,
  output logic              flashMosi,
  input  logic              flashMiso
);
  dpCtrl_t     ctrl;
  logic        xferDone;
  logic [7:0]  rxByte;
  logic [31:0] asmWord;

  msfb_control #(.ADDR_W(ADDR_W), .WIN_AW(WIN_AW), .CLK_DIV(CLK_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .winBase(winBase), .wrEnCode(wrEnCode),
    .hostValid(hostValid), .hostWrite(hostWrite), .hostAddr(hostAddr),
    .hostSize(hostSize), .hostWdata(hostWdata), .xferDone(xferDone),
    .rxByte(rxByte), .asmWord(asmWord), .respAck(respAck),
    .respRetry(respRetry), .respRdata(respRdata), .busy(busy), .ctrl(ctrl)
  );

  msfb_datapath #(.CLK_DIV(CLK_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .flashMiso(flashMiso),
    .xferDone(xferDone), .rxByte(rxByte), .asmWord(asmWord),
    .flashCsN(flashCsN), .flashSck(flashSck), .flashMosi(flashMosi)
  );
endmodule

// File: rtl/msfb_checker.sv
module msfb_checker #(
  parameter int ADDR_W = 32,
  parameter int WIN_AW = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] winBase,
  input logic [1:0]        wrEnCode,
  input logic              hostValid,
  input logic              hostWrite,
  input logic [ADDR_W-1:0] hostAddr,
  input logic [1:0]        hostSize,
  input logic              respAck,
  input logic              respRetry,
  input logic              busy,
  input logic              flashCsN,
  input logic              flashSck,
  input logic              flashMosi
);
  logic [ADDR_W-1:0] chkOff;
  logic              chkIn;
  assign chkOff = hostAddr - winBase;
  assign chkIn  = (hostAddr >= winBase) && ((chkOff >> WIN_AW) == '0);

  AST_NO_CLAIM_NO_RESP: assert property (@(posedge clk) disable iff (!rstN)
    !(hostValid && chkIn) |=> (!respAck && !respRetry)); // R1
  AST_ACK_RETRY_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(respAck && respRetry)); // R3
  AST_RETRY_DURING_PROG: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && chkIn && busy) |=> (respRetry && !respAck)); // R3
  AST_WIDE_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && chkIn && hostWrite && hostSize != 2'd0 && !busy) |=> !busy); // R5
  AST_BLOCKED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && chkIn && hostWrite && wrEnCode == 2'b01 && !busy) |=> !busy); // R6
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    flashCsN |-> !flashSck); // R8
  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (flashSck && $past(flashSck)) |-> $stable(flashMosi)); // R8
endmodule

bind msfb_bridge msfb_checker #(.ADDR_W(ADDR_W), .WIN_AW(WIN_AW)) u_chk (
  .clk(clk), .rstN(rstN), .winBase(winBase), .wrEnCode(wrEnCode),
  .hostValid(hostValid), .hostWrite(hostWrite), .hostAddr(hostAddr),
  .hostSize(hostSize), .respAck(respAck), .respRetry(respRetry),
  .busy(busy), .flashCsN(flashCsN), .flashSck(flashSck), .flashMosi(flashMosi)
);

// File: tb/msfb_bridge_test.sv
`timescale 1ns/1ps
module msfb_bridge_test;
  localparam int ADDR_W  = 32;
  localparam int WIN_AW  = 16;
  localparam int CLK_DIV = 2;
  localparam logic [31:0] BASE = 32'h4000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0]  wrEnCode = 2'b10;
  logic        hostValid = 1'b0, hostWrite = 1'b0;
  logic [31:0] hostAddr = '0;
  logic [1:0]  hostSize = '0;
  logic [7:0]  hostWdata = '0;
  logic        respAck, respRetry, busy, flashCsN, flashSck, flashMosi;
  logic        flashMiso = 1'b0;
  logic [31:0] respRdata;

  always #4 clk = ~clk;

  msfb_bridge #(.ADDR_W(ADDR_W), .WIN_AW(WIN_AW), .CLK_DIV(CLK_DIV)) uut (
    .clk(clk), .rstN(rstN), .winBase(BASE), .wrEnCode(wrEnCode),
    .hostValid(hostValid), .hostWrite(hostWrite), .hostAddr(hostAddr),
    .hostSize(hostSize), .hostWdata(hostWdata), .respAck(respAck),
    .respRetry(respRetry), .respRdata(respRdata), .busy(busy),
    .flashCsN(flashCsN), .flashSck(flashSck), .flashMosi(flashMosi),
    .flashMiso(flashMiso)
  );

  int nChecks = 0, nFail = 0, cyc = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [7:0] fmem [256];
  logic [7:0] shadow [256];
  logic [7:0] fRx, fOp, fTx, fSh, fData;
  logic [23:0] fAddr;
  int fBit, fIdx, fBusyPolls = 0, frames = 0;
  bit fLoad, fWel = 0, fHasData;
  logic [7:0] opLog [$];

  always @(negedge flashCsN) begin
    fBit = 0; fIdx = 0; fLoad = 0; fHasData = 0;
  end
  always @(posedge flashCsN) begin
    frames++;
    if (fOp == 8'h02 && fHasData && fWel) begin
      fmem[fAddr[7:0]] = fData; fWel = 0; fBusyPolls = 3;
    end
  end
  always @(posedge flashSck) if (flashCsN === 1'b0) begin
    fRx = {fRx[6:0], flashMosi};
    fBit++;
    if (fBit == 8) begin
      fBit = 0;
      if (fIdx == 0) begin
        fOp = fRx; opLog.push_back(fRx);
        if (fRx == 8'h06) fWel = 1;
        if (fRx == 8'h05) begin
          fTx = {7'd0, (fBusyPolls > 0)};
          if (fBusyPolls > 0) fBusyPolls--;
          fLoad = 1;
        end
      end else if (fIdx <= 3) begin
        fAddr = {fAddr[15:0], fRx};
        if (fIdx == 3 && fOp == 8'h03) begin fTx = fmem[fAddr[7:0]]; fLoad = 1; end
      end else if (fIdx == 4 && fOp == 8'h02) begin
        fData = fRx; fHasData = 1;
      end
      fIdx++;
    end
  end
  always @(negedge flashSck) if (flashCsN === 1'b0) begin
    if (fLoad) begin flashMiso = fTx[7]; fSh = {fTx[6:0], 1'b0}; fLoad = 0; end
    else begin flashMiso = fSh[7]; fSh = {fSh[6:0], 1'b0}; end
  end

  // ---------------- timing monitors ----------------
  int csHi = 0, minGap = 1000000, sckHi = 0, minHi = 1000000, maxHi = 0;
  bit seenFrame = 0;
  always @(negedge clk) if (rstN) begin
    if (flashCsN) csHi++;
    else begin
      if (seenFrame && csHi > 0 && csHi < minGap) minGap = csHi;
      seenFrame = 1; csHi = 0;
    end
    if (flashSck) sckHi++;
    else if (sckHi > 0) begin
      if (sckHi < minHi) minHi = sckHi;
      if (sckHi > maxHi) maxHi = sckHi;
      sckHi = 0;
    end
  end

  // ---------------- scoreboard ----------------
  logic [31:0] expQ [$];
  string tagQ [$];
  bit rdPending = 0;

  always @(negedge clk) if (rstN && rdPending && respAck) begin
    logic [31:0] e;
    string t;
    e = expQ.pop_front(); t = tagQ.pop_front(); rdPending = 0;
    check(respRdata == e, t, "read data", respRdata, e);
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1; nChecks++; nFail++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  task automatic access(input logic wr, input logic [31:0] addr, input logic [1:0] size,
                        input logic [7:0] wd, output logic ack, output logic rty);
    hostValid = 1'b1; hostWrite = wr; hostAddr = addr; hostSize = size; hostWdata = wd;
    @(negedge clk);
    ack = respAck; rty = respRetry;
    hostValid = 1'b0;
  endtask

  task automatic hostRead(input int off, input logic [1:0] size, input string req,
                          output int retries);
    logic [31:0] exp;
    logic ack, rty;
    int n;
    exp = '0;
    n = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
    for (int k = 0; k < n; k++) exp[8*k +: 8] = shadow[8'(off + k)];
    expQ.push_back(exp); tagQ.push_back(req); rdPending = 1; retries = 0;
    ack = 0;
    for (int t = 0; t < 4000; t++) begin
      access(1'b0, BASE + 32'(off), size, 8'h00, ack, rty);
      if (ack) break;
      if (rty) retries++;
    end
    if (!ack) check(1'b0, req, "read acknowledged", 0, 1);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic waitIdle(input string req);
    int t;
    for (t = 0; t < 20000 && busy; t++) @(negedge clk);
    check(!busy, req, "busy clears", busy, 0);
  endtask

  initial begin
    int r, f0;
    logic ack, rty;
    for (int i = 0; i < 256; i++) begin
      fmem[i] = 8'(i * 13 + 5); shadow[i] = 8'(i * 13 + 5);
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(flashCsN == 1'b1, "R10", "select idle", flashCsN, 1);
    check(flashSck == 1'b0 && busy == 1'b0, "R10", "sck/busy idle", {flashSck, busy}, 0);
    check(!respAck && !respRetry, "R10", "no response", {respAck, respRetry}, 0);

    // R1 unclaimed accesses
    f0 = frames;
    access(1'b0, BASE - 1, 2'd0, 8'h00, ack, rty);
    check(!ack && !rty, "R1", "below window ignored", {ack, rty}, 0);
    access(1'b0, BASE + 32'h1_0000, 2'd2, 8'h00, ack, rty);
    check(!ack && !rty, "R1", "above window ignored", {ack, rty}, 0);
    access(1'b1, BASE + 32'h2_0000, 2'd0, 8'h11, ack, rty);
    repeat (50) @(negedge clk);
    check(frames == f0, "R1", "no flash frames", frames - f0, 0);

    // R2 single byte read with R3 retry
    f0 = frames;
    hostRead(16, 2'd0, "R2 byte read", r);
    check(r >= 1, "R3", "first read retried", r, 1);
    check(frames - f0 == 1, "R2", "one frame per byte", frames - f0, 1);
    check(opLog[$] == 8'h03, "R2", "read opcode", opLog[$], 8'h03);

    // R2 four-byte read, unaligned
    f0 = frames;
    hostRead(33, 2'd2, "R2 word read", r);
    check(frames - f0 == 4, "R2", "four frames for word", frames - f0, 4);
    hostRead(254, 2'd1, "R2 half read", r);

    // R3 retry for a write arriving during a read sequence
    access(1'b0, BASE + 32'd64, 2'd2, 8'h00, ack, rty);
    check(rty && !ack, "R3", "read start retried", {ack, rty}, 1);
    access(1'b1, BASE + 32'd80, 2'd0, 8'h77, ack, rty);
    check(rty && !ack, "R3", "write during sequence retried", {ack, rty}, 1);
    hostRead(64, 2'd2, "R3 repeat read", r);

    // R6 blocked write
    wrEnCode = 2'b01; f0 = frames;
    access(1'b1, BASE + 32'd48, 2'd0, 8'h5A, ack, rty);
    check(ack && !rty && !busy, "R6", "blocked write acked, no busy", {ack, rty, busy}, 3'b100);
    repeat (100) @(negedge clk);
    check(frames == f0 && !busy, "R6", "no flash traffic", frames - f0, 0);
    hostRead(48, 2'd0, "R6 content unchanged", r);

    // R5 wide write dropped
    wrEnCode = 2'b10; f0 = frames;
    access(1'b1, BASE + 32'd48, 2'd2, 8'h5A, ack, rty);
    check(ack && !busy, "R5", "wide write acked, no busy", {ack, busy}, 2'b10);
    repeat (100) @(negedge clk);
    check(frames == f0, "R5", "no flash traffic", frames - f0, 0);

    // R4 / R7 accepted byte write with status polling
    f0 = frames;
    access(1'b1, BASE + 32'd48, 2'd0, 8'hA5, ack, rty);
    check(ack && busy, "R7", "busy with write ack", {ack, busy}, 2'b11);
    access(1'b0, BASE + 32'd48, 2'd0, 8'h00, ack, rty);
    check(rty && !ack, "R3", "read during program retried", {ack, rty}, 1);
    waitIdle("R7");
    shadow[48] = 8'hA5;
    check(frames - f0 == 6, "R7", "polls until status clear", frames - f0, 6);
    check(opLog[$-5] == 8'h06 && opLog[$-4] == 8'h02, "R4", "enable then program",
          {opLog[$-5], opLog[$-4]}, 16'h0602);
    check(opLog[$-3] == 8'h05 && opLog[$] == 8'h05, "R4", "status read opcode",
          {opLog[$-3], opLog[$]}, 16'h0505);
    hostRead(48, 2'd0, "R4 programmed byte", r);

    // R8 / R9 serial timing
    check(minHi == CLK_DIV && maxHi == CLK_DIV, "R8", "sck half period", minHi, CLK_DIV);
    check(minGap >= 4 * CLK_DIV, "R9", "select gap", minGap, 4 * CLK_DIV);

    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R3", "all reads completed", expQ.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule